// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Device Model

This block is a synthesizable model of the device side of a synchronous SRAM that moves data on both halves of its clock. The address, command strobe and read/write select are sampled at the rising edge only. Every access moves a pair of words: the word at offset 0 travels in the high phase of the clock and the word at offset 1 in the low phase. Writes take their two data beats one cycle after the command, and each beat carries its own active-low byte enables. Reads return their two beats after either two or one full cycles, and a valid flag plus an output enable mark exactly the beats that carry read data.

The latency mode is taken from the `dll_on` input while reset is held. It is then frozen until the next reset. In the two-cycle mode the model waits out a lock interval of `LOCK_CYCLES` rising edges after reset and ignores commands until the interval ends. In the one-cycle mode it accepts commands at once. The array holds `2**ADDR_W` word pairs and is cleared by reset. A write that has taken its data but has not yet reached the array is forwarded to a read of the same pair. Commands may arrive on every cycle without stalls.

Top module: `ddr2b_sram`

## Requirements
- R1: A command is accepted only when `ld_n` is low at a rising edge and `locked` is high. Within an accepted command, `rw`=1 selects a read and `rw`=0 a write. Cycles with `ld_n` high, or with `locked` low, start nothing and produce no read beats.
- R2: If `dll_on`=1 during reset, `locked` is low until exactly `LOCK_CYCLES` rising edges after reset release, and then stays high. Commands given before that point have no effect on the array. If `dll_on`=0 during reset, `locked` is high from the first edge after release.
- R3: For a write accepted at edge c, the word at offset 0 of the addressed pair is taken from `wdata` at edge c+1 (rising). The word at offset 1 is taken at the falling edge that follows.
- R4: Byte enables are active-low and apply per beat. Bit i of `bwe_n` covers `wdata[8i+7:8i]`. A byte whose bit is 1 keeps its stored value.
- R5: In two-cycle mode, a read accepted at edge c drives offset 0 from rising edge c+2 until the next falling edge, and offset 1 from that falling edge until rising edge c+3.
- R6: In one-cycle mode, the same beats appear one cycle earlier, starting at rising edge c+1.
- R7: `rvalid` and `rdata_oe` are high during exactly the read beats. At all other times `rdata` is zero.
- R8: Commands on consecutive cycles are all accepted without stalls, and back-to-back reads give a gap-free stream of beats.
- R9: A read accepted on the cycle after a write to the same pair returns the newly written bytes, merged under that write's enables.
- R10: A read accepted the cycle before a write to the same pair returns the old contents.
- R11: Reset clears every array word to zero and leaves the read outputs idle.
- R12: The latency mode is fixed while reset is held. Changing `dll_on` after reset does not change the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; high phase carries beat 0, low phase beat 1 |
| rst_n | input | 1 | Synchronous active-low reset |
| dll_on | input | 1 | 1 selects two-cycle latency with lock interval, sampled during reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 read, 0 write |
| addr | input | ADDR_W | Word-pair address |
| wdata | input | DATA_W | Write data beat |
| bwe_n | input | DATA_W/8 | Active-low byte write enables for the current beat |
| rdata | output | DATA_W | Read data beat, zero when not driven |
| rdata_oe | output | 1 | Output enable for the data bus |
| rvalid | output | 1 | Read beat valid flag |
| locked | output | 1 | Commands are being accepted |

## Verification
On every cycle, the assertions check that the lock flag never falls once raised, that the lock counter stays in range, and that an accepted read turns into a rising-phase beat after exactly the latency of the current mode. They also check that the falling-phase valid follows the rising-phase one within each cycle, and that no beat appears without a request. Only the directed scenarios can show the data itself: per-beat byte merging, forwarding from a pending write, the ordering of a read followed by a write, the clearing of the array by reset, and the effect of commands sent before lock.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

  typedef enum logic {
    LAT_ONE_CYC = 1'b0,
    LAT_TWO_CYC = 1'b1
  } lat_mode_e;

  function automatic int lanes_of(input int width);
    return (width + 7) / 8;
  endfunction

endpackage

// File: rtl/ddr2b_lock.sv
module ddr2b_lock
  import ddr2b_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dll_on,
  output lat_mode_e mode,
  output logic      locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_CYCLES);

  logic [CW-1:0] stable_cnt;
  lat_mode_e     mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= dll_on ? LAT_TWO_CYC : LAT_ONE_CYC;
      stable_cnt <= '0;
    end else if (stable_cnt != LOCK_END) begin
      stable_cnt <= stable_cnt + 1'b1;
    end
  end

  assign mode   = mode_q;
  assign locked = (mode_q == LAT_ONE_CYC) || (stable_cnt == LOCK_END);

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R2
  AST_LOCK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stable_cnt <= LOCK_END); // R2
endmodule

// File: rtl/ddr2b_wpath.sv
module ddr2b_wpath #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NB-1:0]     bwe_n,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_d0,
  output logic [NB-1:0]     wb_m0,
  output logic [DATA_W-1:0] wb_d1,
  output logic [NB-1:0]     wb_m1
);
  // stage A: command seen, data not yet taken
  logic              wa_valid;
  logic [ADDR_W-1:0] wa_addr;
  // falling-edge capture of the second beat
  logic [DATA_W-1:0] fall_d;
  logic [NB-1:0]     fall_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_valid <= 1'b0;
      wa_addr  <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_d0    <= '0;
      wb_m0    <= '1;
    end else begin
      wa_valid <= wr_cmd;
      wa_addr  <= cmd_addr;
      wb_valid <= wa_valid;
      wb_addr  <= wa_addr;
      if (wa_valid) begin
        wb_d0 <= wdata;
        wb_m0 <= bwe_n;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      fall_d <= '0;
      fall_m <= '1;
    end else begin
      fall_d <= wdata;
      fall_m <= bwe_n;
    end
  end

  assign wb_d1 = fall_d;
  assign wb_m1 = fall_m;
endmodule

// File: rtl/ddr2b_core.sv
module ddr2b_core #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_d0,
  input  logic [NB-1:0]     wb_m0,
  input  logic [DATA_W-1:0] wb_d1,
  input  logic [NB-1:0]     wb_m1,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_w0,
  output logic [DATA_W-1:0] rd_w1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem0 [DEPTH];
  logic [DATA_W-1:0] mem1 [DEPTH];
  logic              fwd_hit;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [NB-1:0]     keep_n
  );
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < NB; i++) begin
      if (!keep_n[i]) res[i*8 +: 8] = new_w[i*8 +: 8];
    end
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem0[i] <= '0;
        mem1[i] <= '0;
      end
    end else if (wb_valid) begin
      mem0[wb_addr] <= lane_merge(mem0[wb_addr], wb_d0, wb_m0);
      mem1[wb_addr] <= lane_merge(mem1[wb_addr], wb_d1, wb_m1);
    end
  end

  assign fwd_hit = wb_valid && (wb_addr == rd_addr);

  always_comb begin
    rd_w0 = mem0[rd_addr];
    rd_w1 = mem1[rd_addr];
    if (fwd_hit) begin
      rd_w0 = lane_merge(mem0[rd_addr], wb_d0, wb_m0);
      rd_w1 = lane_merge(mem1[rd_addr], wb_d1, wb_m1);
    end
  end
endmodule

// File: rtl/ddr2b_rpath.sv
module ddr2b_rpath
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lat_mode_e         mode,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] rc_addr,
  input  logic [DATA_W-1:0] core_w0,
  input  logic [DATA_W-1:0] core_w1,
  output logic              rise_valid,
  output logic [DATA_W-1:0] rise_w0,
  output logic              fall_valid,
  output logic [DATA_W-1:0] fall_w1
);
  logic              rc_valid;
  logic              r1_v, r2_v;
  logic [DATA_W-1:0] r1_w0, r1_w1, r2_w0, r2_w1;
  logic [DATA_W-1:0] sel_w1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_valid <= 1'b0;
      rc_addr  <= '0;
      r1_v     <= 1'b0;
      r1_w0    <= '0;
      r1_w1    <= '0;
      r2_v     <= 1'b0;
      r2_w0    <= '0;
      r2_w1    <= '0;
    end else begin
      rc_valid <= rd_req;
      rc_addr  <= req_addr;
      r1_v     <= rc_valid;
      r1_w0    <= core_w0;
      r1_w1    <= core_w1;
      r2_v     <= r1_v;
      r2_w0    <= r1_w0;
      r2_w1    <= r1_w1;
    end
  end

  generate
    always_comb begin
      if (mode == LAT_ONE_CYC) begin
        rise_valid = r1_v;
        rise_w0    = r1_w0;
        sel_w1     = r1_w1;
      end else begin
        rise_valid = r2_v;
        rise_w0    = r2_w0;
        sel_w1     = r2_w1;
      end
    end
  endgenerate

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      fall_valid <= 1'b0;
      fall_w1    <= '0;
    end else begin
      fall_valid <= rise_valid;
      fall_w1    <= sel_w1;
    end
  end

  AST_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LAT_ONE_CYC && rd_req) |=> ##1 rise_valid); // R6
  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LAT_TWO_CYC && rd_req) |=> ##2 rise_valid); // R5
  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_valid == rise_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LAT_ONE_CYC && !rd_req) |=> ##1 !rise_valid); // R1
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int LOCK_CYCLES = 2048
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dll_on,
  input  logic                     ld_n,
  input  logic                     rw,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [lanes_of(DATA_W)-1:0] bwe_n,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe,
  output logic                     rvalid,
  output logic                     locked
);
  localparam int NB = lanes_of(DATA_W);

  lat_mode_e         mode;
  logic              cmd_ok, rd_req, wr_cmd;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr, rc_addr;
  logic [DATA_W-1:0] wb_d0, wb_d1, core_w0, core_w1, rise_w0, fall_w1;
  logic [NB-1:0]     wb_m0, wb_m1;
  logic              rise_valid, fall_valid;

  assign cmd_ok = !ld_n && locked;
  assign rd_req = cmd_ok && rw;
  assign wr_cmd = cmd_ok && !rw;

  ddr2b_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .dll_on(dll_on), .mode(mode), .locked(locked)
  );

  ddr2b_wpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB)) u_wpath (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cmd_addr(addr),
    .wdata(wdata), .bwe_n(bwe_n), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_d0(wb_d0), .wb_m0(wb_m0), .wb_d1(wb_d1), .wb_m1(wb_m1)
  );

  ddr2b_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB)) u_core (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_d0(wb_d0), .wb_m0(wb_m0), .wb_d1(wb_d1), .wb_m1(wb_m1),
    .rd_addr(rc_addr), .rd_w0(core_w0), .rd_w1(core_w1)
  );

  ddr2b_rpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rpath (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_req(rd_req), .req_addr(addr),
    .rc_addr(rc_addr), .core_w0(core_w0), .core_w1(core_w1),
    .rise_valid(rise_valid), .rise_w0(rise_w0),
    .fall_valid(fall_valid), .fall_w1(fall_w1)
  );

  // high phase shows beat 0, low phase shows beat 1
  always_comb begin
    rvalid   = clk ? rise_valid : fall_valid;
    rdata_oe = rvalid;
    rdata    = '0;
    if (rvalid) rdata = clk ? rise_w0 : fall_w1;
  end
endmodule

// File: tb/ddr2b_sram_bench.sv
`timescale 1ns/1ps
module ddr2b_sram_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LOCKN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dll_on = 1'b1;
  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    bwe_n = 2'b11;
  logic [DW-1:0] rdata;
  logic          rdata_oe, rvalid, locked;

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int lat = 2;
  bit done = 0;

  logic          ov0 [256];
  logic          ov1 [256];
  logic          ooe0 [256];
  logic          olk [256];
  logic [DW-1:0] od0 [256];
  logic [DW-1:0] od1 [256];

  always #2 clk = ~clk;

  ddr2b_sram #(.ADDR_W(AW), .DATA_W(DW), .LOCK_CYCLES(LOCKN)) u_ddr2b_sram (
    .clk(clk), .rst_n(rst_n), .dll_on(dll_on), .ld_n(ld_n), .rw(rw),
    .addr(addr), .wdata(wdata), .bwe_n(bwe_n), .rdata(rdata),
    .rdata_oe(rdata_oe), .rvalid(rvalid), .locked(locked)
  );

  function automatic logic [DW-1:0] bmerge(logic [DW-1:0] o, logic [DW-1:0] n, logic [1:0] m);
    logic [DW-1:0] r = o;
    if (m[0] == 1'b0) r[7:0]  = n[7:0];
    if (m[1] == 1'b0) r[15:8] = n[15:8];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc_n);
    end
  endtask

  // one clock: entered 1 ns after a falling edge
  task automatic cyc(bit l, bit r, int a, logic [DW-1:0] d0, logic [1:0] m0,
                     logic [DW-1:0] d1, logic [1:0] m1);
    ld_n = l; rw = r; addr = AW'(a); wdata = d0; bwe_n = m0;
    @(posedge clk); #1;
    cyc_n++;
    ov0[cyc_n % 256] = rvalid; od0[cyc_n % 256] = rdata;
    ooe0[cyc_n % 256] = rdata_oe; olk[cyc_n % 256] = locked;
    wdata = d1; bwe_n = m1;
    @(negedge clk); #1;
    ov1[cyc_n % 256] = rvalid; od1[cyc_n % 256] = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11);
  endtask

  task automatic chk_read(string req, int c, logic [DW-1:0] e0, logic [DW-1:0] e1);
    int k = (c + lat) % 256;
    chk({req, " beat0 valid"}, ov0[k], 1'b1);
    chk({req, " beat0 oe"}, ooe0[k], 1'b1);
    chk({req, " beat0 data"}, od0[k], e0);
    chk({req, " beat1 valid"}, ov1[k], 1'b1);
    chk({req, " beat1 data"}, od1[k], e1);
  endtask

  task automatic chk_quiet(string req, int c);
    chk({req, " no beat0"}, ov0[c % 256], 1'b0);
    chk({req, " no oe"}, ooe0[c % 256], 1'b0);
    chk({req, " bus zero"}, od0[c % 256], '0);
    chk({req, " no beat1"}, ov1[c % 256], 1'b0);
  endtask

  task automatic do_reset(bit m);
    rst_n = 1'b0; dll_on = m;
    idle(3);
    rst_n = 1'b1;
  endtask

  // R11: outputs idle after reset; R2: locked low in two-cycle mode
  task automatic t_reset_state();
    do_reset(1'b1);
    lat = 2;
    chk_quiet("R11", cyc_n);
    chk("R2 locked low during reset", olk[cyc_n % 256], 1'b0);
  endtask

  // R2, R1: lock interval length and commands ignored before lock
  task automatic t_lock();
    cyc(0, 0, 3, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(1, 0, 0, 16'h5A5A, 2'b00, 16'hA5A5, 2'b00);
    idle(LOCKN - 3);
    chk("R2 locked low at edge LOCK-1", olk[cyc_n % 256], 1'b0);
    idle(1);
    chk("R2 locked high at edge LOCK", olk[cyc_n % 256], 1'b1);
    cyc(0, 1, 3, 16'h0, 2'b11, 16'h0, 2'b11);
    begin
      int c = cyc_n;
      idle(4);
      chk_read("R2 early write ignored", c, 16'h0, 16'h0);
      chk_quiet("R1 idle after read", c + lat + 1);
    end
  endtask

  // R3, R5, R7: plain write then read in two-cycle mode
  task automatic t_write_read();
    int c;
    cyc(0, 0, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(1, 0, 0, 16'hA1B2, 2'b00, 16'hC3D4, 2'b00);
    idle(2);
    cyc(0, 1, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    c = cyc_n;
    idle(4);
    chk_read("R3 R5", c, 16'hA1B2, 16'hC3D4);
    chk_quiet("R5 not early", c + 1);
    chk_quiet("R7 not late", c + 3);
  endtask

  // R4: per-beat byte enables
  task automatic t_masks();
    int c;
    cyc(0, 0, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(1, 0, 0, 16'h1111, 2'b10, 16'h2222, 2'b01);
    cyc(0, 0, 6, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(1, 0, 0, 16'h7777, 2'b11, 16'h8888, 2'b11);
    idle(1);
    cyc(0, 1, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    c = cyc_n;
    cyc(0, 1, 6, 16'h0, 2'b11, 16'h0, 2'b11);
    idle(4);
    chk_read("R4 per-beat lanes", c, bmerge(16'hA1B2, 16'h1111, 2'b10),
             bmerge(16'hC3D4, 16'h2222, 2'b01));
    chk_read("R4 all masked keeps", c + 1, 16'h0, 16'h0);
  endtask

  // R9: read right after write forwards the pending data
  task automatic t_forward();
    int c;
    cyc(0, 0, 9, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(0, 1, 9, 16'h1234, 2'b01, 16'h5678, 2'b00);
    c = cyc_n;
    idle(4);
    chk_read("R9 forward", c, bmerge(16'h0, 16'h1234, 2'b01), 16'h5678);
  endtask

  // R10: read before write sees old data
  task automatic t_rd_then_wr();
    int c1, c2;
    cyc(0, 1, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    c1 = cyc_n;
    cyc(0, 0, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(1, 0, 0, 16'hBEEF, 2'b00, 16'hCAFE, 2'b00);
    cyc(0, 1, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    c2 = cyc_n;
    idle(4);
    chk_read("R10 old data", c1, 16'hA111, 16'h22D4);
    chk_read("R10 new data later", c2, 16'hBEEF, 16'hCAFE);
  endtask

  // R8: back-to-back commands, gap-free beats
  task automatic t_b2b();
    int c;
    cyc(0, 0, 1, 16'h0, 2'b11, 16'h0, 2'b11);
    c = cyc_n;
    cyc(0, 0, 2, 16'h1111, 2'b00, 16'h2222, 2'b00);
    cyc(0, 1, 1, 16'h3333, 2'b00, 16'h4444, 2'b00);
    cyc(0, 1, 2, 16'h0, 2'b11, 16'h0, 2'b11);
    idle(5);
    chk_read("R8 first", c + 2, 16'h1111, 16'h2222);
    chk_read("R8 second", c + 3, 16'h3333, 16'h4444);
    chk_quiet("R8 stream ends", c + 4 + lat);
  endtask

  // R12: mode frozen after reset
  task automatic t_mode_frozen();
    int c;
    dll_on = 1'b0;
    cyc(0, 1, 1, 16'h0, 2'b11, 16'h0, 2'b11);
    c = cyc_n;
    idle(4);
    chk_quiet("R12 no one-cycle beat", c + 1);
    chk_read("R12 still two-cycle", c, 16'h1111, 16'h2222);
  endtask

  // R6, R11, R2: one-cycle mode after a fresh reset
  task automatic t_lat_one();
    int c;
    do_reset(1'b0);
    lat = 1;
    cyc(0, 1, 5, 16'h0, 2'b11, 16'h0, 2'b11);
    c = cyc_n;
    chk("R2 locked at once when dll off", olk[c % 256], 1'b1);
    cyc(0, 0, 7, 16'h0, 2'b11, 16'h0, 2'b11);
    cyc(0, 1, 7, 16'h9ABC, 2'b00, 16'hDEF0, 2'b10);
    idle(3);
    chk_read("R11 array cleared", c, 16'h0, 16'h0);
    chk_quiet("R6 gap after read", c + 2);
    chk_read("R6 one-cycle forward", c + 2, 16'h9ABC, bmerge(16'h0, 16'hDEF0, 2'b10));
    chk_quiet("R6 quiet after", c + 4);
  endtask

  initial begin
    @(negedge clk); #1;
    t_reset_state();
    t_lock();
    t_write_read();
    t_masks();
    t_forward();
    t_rd_then_wr();
    t_b2b();
    t_mode_frozen();
    t_lat_one();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule